// File: doc/BRIEF.md
# Recorded Region Replay Prefetcher

This block replays sequences of instruction regions that were seen before. A separate recorder feeds it compacted region records. Each record holds a trigger block address and two bit vectors: one for the blocks just below the trigger and one for the blocks just above it. The block writes each record into a circular history at a wrapping tail slot. It also keeps a small set-associative index that maps each trigger to the slot where that trigger was last written.

When a demand miss address arrives, the block looks it up in the index. On a hit whose slot still holds that trigger, a stream window starts at that slot. The window walks forward through a fixed number of consecutive records. It expands every set bit of each record into a prefetch block address and issues one address per cycle on a valid/ready output. The stream ends early when it reaches the history tail.

Top module: `hist_stream_pf`

## Requirements
- R1: After reset `pf_valid` is 0, the index holds no entries, and a lookup made before any record write produces no prefetch.
- R2: Each asserted `rec_valid` writes one record at the tail slot and moves the tail by one, wrapping after slot DEPTH-1. A record written into an occupied slot replaces the oldest record.
- R3: Every record write creates or updates the index entry for its trigger so that it points at the slot just written. A trigger written again is replayed from its newest slot.
- R4: A lookup that misses the index produces no prefetch and leaves a running stream exactly as it was.
- R5: A lookup whose index entry points at a slot now holding a different trigger is treated as a miss.
- R6: A hit starts a window of at most WINDOW consecutive records beginning at the indexed slot. The window stops before reaching the tail slot.
- R7: Within one record the trigger block is issued first. Next come the preceding blocks: bit i of `rec_prec` gives trigger-(i+1), taken in increasing i. Last come the succeeding blocks: bit i of `rec_succ` gives trigger+(i+1), taken in increasing i. Clear bits issue nothing.
- R8: The window pointer moves from slot DEPTH-1 to slot 0.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, `pf_addr` and `pf_valid` hold, and a lookup arriving in such a cycle is ignored.
- R10: The index set is the low log2(SETS) bits of the trigger, and the rest of the trigger is the tag. A new trigger takes a free way if the set has one, and otherwise replaces the least recently used way. Record writes and accepted lookup hits both count as use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rec_valid | input | 1 | Record write strobe |
| rec_trigger | input | ADDR_W | Trigger block address of the record |
| rec_prec | input | PREC_N | Preceding-block bit vector |
| rec_succ | input | SUCC_N | Succeeding-block bit vector |
| miss_valid | input | 1 | Demand miss lookup strobe |
| miss_addr | input | ADDR_W | Demand miss block address |
| pf_valid | output | 1 | Prefetch address valid |
| pf_ready | input | 1 | Consumer accepts the prefetch address |
| pf_addr | output | ADDR_W | Prefetch block address |

## Verification
The assertions check four things on every cycle: that a stalled output holds, that no stream starts without a verified index hit, that the tail steps exactly when a record is written, and that at most one way of a set matches a lookup. Only the bench's scenarios can show the rest. That covers the exact issue order inside each record and where a window ends at the window limit or at the tail. It also covers the wrap from the last slot, stale-slot rejection after overwrite, and which way least-recently-used replacement evicts.

// File: rtl/hist_stream_pf.sv
module hist_stream_pf #(
  parameter int ADDR_W = 32,
  parameter int PREC_N = 4,
  parameter int SUCC_N = 8,
  parameter int DEPTH  = 16,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int WINDOW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [ADDR_W-1:0] rec_trigger,
  input  logic [PREC_N-1:0] rec_prec,
  input  logic [SUCC_N-1:0] rec_succ,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int HW = $clog2(DEPTH);
  localparam int SW = $clog2(SETS);
  localparam int AW = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TW = ADDR_W - SW;
  localparam int MW = 1 + PREC_N + SUCC_N;
  localparam int BW = $clog2(MW);
  localparam int CW = $clog2(WINDOW + 1);

  logic [ADDR_W-1:0] h_trig [DEPTH];
  logic [MW-1:0]     h_mask [DEPTH];
  logic [HW-1:0]     tail;

  logic          ix_v   [SETS][WAYS];
  logic [TW-1:0] ix_tag [SETS][WAYS];
  logic [HW-1:0] ix_ptr [SETS][WAYS];
  logic [AW-1:0] ix_age [SETS][WAYS];

  logic              active;
  logic [HW-1:0]     ptr;
  logic [MW-1:0]     pend;
  logic [ADDR_W-1:0] cur_trig;
  logic [CW-1:0]     left;

  wire [SW-1:0] ws = rec_trigger[SW-1:0];
  wire [TW-1:0] wt = rec_trigger[ADDR_W-1:SW];
  wire [SW-1:0] ls = miss_addr[SW-1:0];
  wire [TW-1:0] lt = miss_addr[ADDR_W-1:SW];

  logic          w_hit, w_free;
  logic [AW-1:0] w_way, w_fway, w_lway, w_sel;
  always_comb begin
    w_hit = 1'b0; w_free = 1'b0;
    w_way = '0; w_fway = '0; w_lway = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ix_v[ws][w] && ix_tag[ws][w] == wt) begin w_hit = 1'b1; w_way = AW'(w); end
      if (!ix_v[ws][w] && !w_free) begin w_free = 1'b1; w_fway = AW'(w); end
      if (ix_age[ws][w] == AW'(WAYS - 1)) w_lway = AW'(w);
    end
    w_sel = w_hit ? w_way : (w_free ? w_fway : w_lway);
  end

  logic [WAYS-1:0] l_hitv;
  logic [AW-1:0]   l_way;
  logic [HW-1:0]   l_ptr;
  always_comb begin
    l_way = '0; l_ptr = '0;
    for (int w = 0; w < WAYS; w++) begin
      l_hitv[w] = ix_v[ls][w] && ix_tag[ls][w] == lt;
      if (l_hitv[w]) begin l_way = AW'(w); l_ptr = ix_ptr[ls][w]; end
    end
  end

  wire l_ok  = (|l_hitv) && h_trig[l_ptr] == miss_addr;
  wire stall = pf_valid && !pf_ready;
  wire load  = miss_valid && l_ok && !stall;

  logic [BW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int b = MW - 1; b >= 0; b--)
      if (pend[b]) sel = BW'(b);
  end

  wire [MW-1:0] pend_clr = pend & ~(MW'(1) << sel);
  wire [HW-1:0] nxt      = (ptr == HW'(DEPTH - 1)) ? '0 : ptr + 1'b1;

  assign pf_valid = active;
  assign pf_addr  = (sel == '0) ? cur_trig :
                    (int'(sel) <= PREC_N) ? cur_trig - ADDR_W'(sel) :
                                            cur_trig + ADDR_W'(int'(sel) - PREC_N);

  always_ff @(posedge clk) begin
    if (rec_valid) begin
      h_trig[tail] <= rec_trigger;
      h_mask[tail] <= {rec_succ, rec_prec, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          ix_v[s][w]   <= 1'b0;
          ix_tag[s][w] <= '0;
          ix_ptr[s][w] <= '0;
          ix_age[s][w] <= AW'(w);
        end
    end else begin
      if (rec_valid) begin
        tail <= (tail == HW'(DEPTH - 1)) ? '0 : tail + 1'b1;
        ix_v[ws][w_sel]   <= 1'b1;
        ix_tag[ws][w_sel] <= wt;
        ix_ptr[ws][w_sel] <= tail;
        for (int w = 0; w < WAYS; w++)
          if (AW'(w) == w_sel) ix_age[ws][w] <= '0;
          else if (ix_age[ws][w] < ix_age[ws][w_sel]) ix_age[ws][w] <= ix_age[ws][w] + 1'b1;
      end
      if (load && !(rec_valid && ls == ws)) begin
        for (int w = 0; w < WAYS; w++)
          if (AW'(w) == l_way) ix_age[ls][w] <= '0;
          else if (ix_age[ls][w] < ix_age[ls][l_way]) ix_age[ls][w] <= ix_age[ls][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      ptr      <= '0;
      pend     <= '0;
      cur_trig <= '0;
      left     <= '0;
    end else if (load) begin
      active   <= 1'b1;
      ptr      <= l_ptr;
      pend     <= h_mask[l_ptr];
      cur_trig <= h_trig[l_ptr];
      left     <= CW'(WINDOW - 1);
    end else if (active && pf_ready) begin
      if (pend_clr != '0) pend <= pend_clr;
      else if (left == '0 || nxt == tail) active <= 1'b0;
      else begin
        ptr      <= nxt;
        pend     <= h_mask[nxt];
        cur_trig <= h_trig[nxt];
        left     <= left - 1'b1;
      end
    end
  end
endmodule

module hist_stream_pf_chk #(
  parameter int ADDR_W = 32,
  parameter int HW     = 4,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              miss_valid,
  input logic              l_ok,
  input logic              rec_valid,
  input logic [HW-1:0]     tail,
  input logic [WAYS-1:0]   l_hitv
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));
  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid && !(miss_valid && l_ok) |=> !pf_valid);
  // R2
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> tail != $past(tail));
  // R2
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |=> $stable(tail));
  // R10
  one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_hitv));
endmodule

bind hist_stream_pf hist_stream_pf_chk #(.ADDR_W(ADDR_W), .HW(HW), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
  .miss_valid(miss_valid), .l_ok(l_ok), .rec_valid(rec_valid), .tail(tail), .l_hitv(l_hitv));

// File: tb/tb_hist_stream_pf.sv
module tb_hist_stream_pf;
  localparam int DEPTH = 16;
  localparam int NR = 6;
  localparam int NL = 6;
  // {trigger, prec, succ}
  localparam logic [43:0] RECS [NR] = '{
    {32'h101, 4'b0011, 8'h05}, {32'h202, 4'b0000, 8'h00}, {32'h303, 4'b1000, 8'h81},
    {32'h404, 4'b0101, 8'h0F}, {32'h505, 4'b1111, 8'hFF}, {32'h606, 4'b0010, 8'h40}};
  // {lookup address, first slot, record count}
  localparam logic [47:0] LOOKS [NL] = '{
    {32'h101, 8'd0, 8'd4}, {32'h404, 8'd3, 8'd3}, {32'h606, 8'd5, 8'd1},
    {32'h777, 8'd0, 8'd0}, {32'h1101, 8'd0, 8'd0}, {32'h303, 8'd2, 8'd4}};

  logic clk = 0, rst_n = 0;
  logic rec_valid = 0, miss_valid = 0, pf_ready = 1;
  logic [31:0] rec_trigger = 0, miss_addr = 0;
  logic [3:0] rec_prec = 0;
  logic [7:0] rec_succ = 0;
  logic pf_valid;
  logic [31:0] pf_addr;
  int total = 0, bad = 0;

  logic [31:0] m_trig [DEPTH];
  logic [3:0]  m_prec [DEPTH];
  logic [7:0]  m_succ [DEPTH];
  int m_tail = 0;
  logic [31:0] e [256];
  logic [31:0] g [256];

  always #5 clk = ~clk;

  hist_stream_pf dut (.clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_trigger(rec_trigger),
    .rec_prec(rec_prec), .rec_succ(rec_succ), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic write_rec(input logic [31:0] t, input logic [3:0] p, input logic [7:0] s);
    @(negedge clk);
    rec_valid = 1; rec_trigger = t; rec_prec = p; rec_succ = s;
    m_trig[m_tail] = t; m_prec[m_tail] = p; m_succ[m_tail] = s;
    m_tail = (m_tail + 1) % DEPTH;
    @(negedge clk);
    rec_valid = 0;
  endtask

  task automatic collect(input int slot, input int nrec, input bit inj, input logic [31:0] ia, input string req);
    int ne = 0, n = 0, idle = 0, bad_i = -1;
    for (int r = 0; r < nrec; r++) begin
      int k = (slot + r) % DEPTH;
      e[ne++] = m_trig[k];
      for (int b = 0; b < 4; b++) if (m_prec[k][b]) e[ne++] = m_trig[k] - 32'(b + 1);
      for (int b = 0; b < 8; b++) if (m_succ[k][b]) e[ne++] = m_trig[k] + 32'(b + 1);
    end
    pf_ready = 1;
    for (int c = 0; c < 300 && idle < 3; c++) begin
      if (pf_valid) begin
        if (n < 256) g[n] = pf_addr;
        n++; idle = 0;
        if (inj && n == 2) begin miss_valid = 1; miss_addr = ia; end
      end else idle++;
      @(negedge clk);
      miss_valid = 0;
    end
    chk(n == ne, {req, " count"}, 32'(n), 32'(ne));
    for (int i = 0; i < ne && i < n; i++) if (bad_i < 0 && g[i] !== e[i]) bad_i = i;
    chk(bad_i < 0, {req, " order"}, (bad_i < 0) ? 32'h0 : g[bad_i], (bad_i < 0) ? 32'h0 : e[bad_i]);
  endtask

  task automatic run_lookup(input logic [31:0] a, input int slot, input int nrec,
                            input bit inj, input logic [31:0] ia, input string req);
    @(negedge clk);
    miss_valid = 1; miss_addr = a;
    @(negedge clk);
    miss_valid = 0;
    collect(slot, nrec, inj, ia, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pf_valid == 0, "R1 reset valid", 32'(pf_valid), 0);
    run_lookup(32'h101, 0, 0, 0, 0, "R1 empty index");

    for (int i = 0; i < NR; i++)
      write_rec(RECS[i][43:12], RECS[i][11:8], RECS[i][7:0]);
    for (int i = 0; i < NL; i++)
      run_lookup(LOOKS[i][47:16], int'(LOOKS[i][15:8]), int'(LOOKS[i][7:0]), 0, 0, "R6 R7 table");

    run_lookup(32'h101, 0, 4, 1, 32'h777, "R4 miss keeps stream");

    pf_ready = 0;
    @(negedge clk);
    miss_valid = 1; miss_addr = 32'h202;
    @(negedge clk);
    miss_valid = 0;
    for (int c = 0; c < 3; c++) begin
      chk(pf_valid && pf_addr == 32'h202, "R9 stall hold", pf_addr, 32'h202);
      if (c == 1) begin miss_valid = 1; miss_addr = 32'h505; end
      @(negedge clk);
      miss_valid = 0;
    end
    collect(1, 4, 0, 0, "R9 stall ignores lookup");

    write_rec(32'h303, 4'b0001, 8'h02);
    run_lookup(32'h303, 6, 1, 0, 0, "R3 newest slot");

    for (int i = 7; i < 16; i++) write_rec(32'h1000 + 32'(i), 4'b0001, 8'h01);
    write_rec(32'h2000, 4'b0000, 8'h03);
    run_lookup(32'h100F, 15, 2, 0, 0, "R8 wrap");
    run_lookup(32'h101, 0, 0, 0, 0, "R5 stale slot");
    run_lookup(32'h2000, 0, 1, 0, 0, "R2 overwrite");

    write_rec(32'h200C, 4'b0000, 8'h01);
    write_rec(32'h300C, 4'b0000, 8'h01);
    write_rec(32'h400C, 4'b0000, 8'h01);
    run_lookup(32'h100C, 12, 4, 0, 0, "R10 touch");
    write_rec(32'h500C, 4'b0000, 8'h01);
    run_lookup(32'h200C, 0, 0, 0, 0, "R10 lru evicted");
    run_lookup(32'h300C, 2, 3, 0, 0, "R10 survivor");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule